// File: doc/BRIEF.md
# Instruction Queue Status Encoder

The block holds a short prefetch queue of program words and reports its activity on a two-bit status bus. The bus carries two different codes within one bus cycle. While the phase input is low it shows what the queue did: either it held still or it shifted and took a new word from the data bus. While phase is high it shows how execution started: an interrupt, an instruction beginning in the high byte, an instruction beginning in the low byte, or a continuation. The execution-start code is held back by one extra bus cycle. This makes it line up with the oldest queue stage, where execution reads its bytes.

Each rising edge of `clk` closes one bus cycle. Program words enter through `bus_data_i`, qualified by `adv_i`. That strobe acts as the valid of the input stream. The stream has no ready signal, because a shifting queue accepts every word offered. The execution-start arbiter looks at the start byte in the oldest stage. If that byte is the page-two prebyte 0x18, it is its own one-byte instruction, and no interrupt may be taken at the boundary that follows it. An interrupt arriving there waits for a later instruction start.

Top module: `iq_status_enc`

## Requirements
- R1: While `rst` is high at a clock edge, all stages and valid flags clear to zero after that edge, and `qstat_o` reads 00 in both phases.
- R2: A cycle with `adv_i` high shifts every stage one place toward the oldest. Stage one (bits [15:0]) takes `bus_data_i`. The new contents show in the following cycle.
- R3: A cycle with `adv_i` low leaves all stage contents and valid flags unchanged.
- R4: With `phase_i` low, `qstat_o` shows the movement code of the previous cycle: 10 if `adv_i` was high, else 00.
- R5: With `phase_i` high, `qstat_o` shows the execution-start code of the event from two cycles earlier. The codes are 00 continue, 01 interrupt, 10 even start, 11 odd start.
- R6: An even start (`st_even_i`) takes its start byte from the high byte of the oldest stage, bits [47:40]. An odd start (`st_odd_i`) takes it from the low byte, bits [39:32]. If both are high, the even start wins.
- R7: An accepted instruction start whose start byte is 0x18 still reports its own start code. It also blocks interrupts until the next instruction start. An interrupt requested while blocked is not reported, and the instruction start code (or 00) appears instead.
- R8: A deferred interrupt is reported (code 01) at the first instruction start after the block has cleared, in place of that start's code.
- R9: When an interrupt and an instruction start are requested in the same cycle and no block is active, code 01 is reported.
- R10: Valid flags shift with the data: stage one's flag is set on every advance, and each older flag takes its neighbour's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock; each rising edge ends a cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 1 | Half-cycle select for the status bus (0 movement, 1 execution start) |
| adv_i | input | 1 | Queue advance; valid of the incoming program word |
| bus_data_i | input | 16 | Program word from the data bus |
| st_even_i | input | 1 | Instruction start in the high byte of the oldest stage |
| st_odd_i | input | 1 | Instruction start in the low byte of the oldest stage |
| st_int_i | input | 1 | Interrupt start request |
| stage_o | output | 48 | Queue contents; stage one at [15:0], the oldest stage at [47:32] |
| valid_o | output | 3 | Per-stage valid flags; bit 0 is stage one |
| qstat_o | output | 2 | Multiplexed queue status code |

## Verification
A word loaded in cycle n shows in `stage_o` and `valid_o` in cycle n+1. The movement code for cycle n is due in cycle n+1 while phase is low. The execution-start code for an event in cycle n is due in cycle n+2 while phase is high. The bench drives inputs just after the falling edge. It reads the outputs at the next falling edge and toggles `phase_i` there to read both codes. Its model and its hand-computed expectations pass through two-entry delay lines, so each start code is compared in exactly its due cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    MV_HOLD = 2'b00,
    MV_LOAD = 2'b10
  } mov_code_e;

  typedef enum logic [1:0] {
    EX_CONT = 2'b00,
    EX_INT  = 2'b01,
    EX_EVEN = 2'b10,
    EX_ODD  = 2'b11
  } exec_code_e;

  localparam logic [7:0] PREBYTE = 8'h18;
endpackage

// File: rtl/iq_queue.sv
module iq_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] stages,
  output logic [DEPTH-1:0]   valids
);
  logic [W-1:0]     st_q [DEPTH];
  logic [DEPTH-1:0] vl_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          st_q[k] <= '0;
          vl_q[k] <= 1'b0;
        end else if (adv) begin
          st_q[k] <= din;
          vl_q[k] <= 1'b1;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          st_q[k] <= '0;
          vl_q[k] <= 1'b0;
        end else if (adv) begin
          st_q[k] <= st_q[k-1];
          vl_q[k] <= vl_q[k-1];
        end
      end
    end
    assign stages[k*W +: W] = st_q[k];
  end

  assign valids = vl_q;

  // R10
  valid_shift_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> valids[0]);
endmodule

// File: rtl/iq_start_arb.sv
module iq_start_arb
  import iq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         st_even,
  input  logic         st_odd,
  input  logic         st_int,
  input  logic [W-1:0] oldest,
  output logic [1:0]   evt_code
);
  localparam int BW = 8;

  logic          blk_q, pend_q;
  logic [BW-1:0] sbyte;
  logic          any_start, take_int;

  assign any_start = st_even | st_odd;
  assign sbyte     = st_even ? oldest[W-1 -: BW] : oldest[BW-1:0];
  assign take_int  = !blk_q && (st_int || (pend_q && any_start));

  always_comb begin
    if (take_int)     evt_code = EX_INT;
    else if (st_even) evt_code = EX_EVEN;
    else if (st_odd)  evt_code = EX_ODD;
    else              evt_code = EX_CONT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (take_int) begin
        blk_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (any_start) blk_q <= (sbyte == PREBYTE);
        if (st_int && blk_q) pend_q <= 1'b1;
      end
    end
  end

  // R7
  prebyte_block_chk: assert property (@(posedge clk) disable iff (rst)
    blk_q |-> evt_code != EX_INT);

  // R8
  pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (st_int && blk_q) |=> pend_q);
endmodule

// File: rtl/iq_status_mux.sv
module iq_status_mux
  import iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phase,
  input  logic       adv,
  input  logic [1:0] evt_code,
  output logic [1:0] qstat
);
  logic [1:0] mov_q, evt_q, exec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mov_q  <= MV_HOLD;
      evt_q  <= EX_CONT;
      exec_q <= EX_CONT;
    end else begin
      mov_q  <= adv ? MV_LOAD : MV_HOLD;
      evt_q  <= evt_code;
      exec_q <= evt_q;
    end
  end

  assign qstat = phase ? exec_q : mov_q;

  // R5
  exec_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(evt_q) |=> exec_q == $past(evt_q));
endmodule

// File: rtl/iq_status_enc.sv
module iq_status_enc
  import iq_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phase_i,
  input  logic               adv_i,
  input  logic [W-1:0]       bus_data_i,
  input  logic               st_even_i,
  input  logic               st_odd_i,
  input  logic               st_int_i,
  output logic [DEPTH*W-1:0] stage_o,
  output logic [DEPTH-1:0]   valid_o,
  output logic [1:0]         qstat_o
);
  localparam int OLD_LO = (DEPTH-1)*W;

  logic [1:0] evt_code;

  iq_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .adv(adv_i), .din(bus_data_i),
    .stages(stage_o), .valids(valid_o)
  );

  iq_start_arb #(.W(W)) u_arb (
    .clk(clk), .rst(rst), .st_even(st_even_i), .st_odd(st_odd_i),
    .st_int(st_int_i), .oldest(stage_o[OLD_LO +: W]), .evt_code(evt_code)
  );

  iq_status_mux u_mux (
    .clk(clk), .rst(rst), .phase(phase_i), .adv(adv_i),
    .evt_code(evt_code), .qstat(qstat_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_o == '0) && (valid_o == '0) && (qstat_o == 2'b00));

  // R2
  shift_load_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (stage_o[DEPTH*W-1:W] == $past(stage_o[(DEPTH-1)*W-1:0]))
              && (stage_o[W-1:0] == $past(bus_data_i)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(stage_o) && $stable(valid_o));

  // R4
  move_code_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(adv_i && !rst) && !phase_i) |-> qstat_o == 2'b10);
endmodule

// File: tb/sim_iq_status_enc.sv
module sim_iq_status_enc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_i = 1'b0, adv_i = 1'b0;
  logic [15:0] bus_data_i = '0;
  logic        st_even_i = 1'b0, st_odd_i = 1'b0, st_int_i = 1'b0;
  logic [47:0] stage_o;
  logic [2:0]  valid_o;
  logic [1:0]  qstat_o;

  int checks = 0, errors = 0;

  logic [15:0] mq [3];
  logic [2:0]  mv;
  logic [1:0]  mmov, mevt, mexec;
  logic        mblk, mpend;
  logic [1:0]  exp1, exp2;
  logic        chk1, chk2;
  string       tag1, tag2;

  iq_status_enc u0 (
    .clk(clk), .rst(rst), .phase_i(phase_i), .adv_i(adv_i),
    .bus_data_i(bus_data_i), .st_even_i(st_even_i), .st_odd_i(st_odd_i),
    .st_int_i(st_int_i), .stage_o(stage_o), .valid_o(valid_o), .qstat_o(qstat_o)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) mq[k] = '0;
    mv = '0; mmov = 2'b00; mevt = 2'b00; mexec = 2'b00;
    mblk = 1'b0; mpend = 1'b0;
    chk1 = 1'b0; chk2 = 1'b0; exp1 = '0; exp2 = '0; tag1 = ""; tag2 = "";
  endtask

  task automatic observe();
    chk("R2 stages", stage_o, {mq[2], mq[1], mq[0]});
    chk("R10 valids", {45'd0, valid_o}, {45'd0, mv});
    phase_i = 1'b0; #1;
    chk("R4 movement", {46'd0, qstat_o}, {46'd0, mmov});
    phase_i = 1'b1; #1;
    chk("R5 exec", {46'd0, qstat_o}, {46'd0, mexec});
    if (chk2) chk(tag2, {46'd0, qstat_o}, {46'd0, exp2});
    phase_i = 1'b0;
  endtask

  task automatic step(input logic a, input logic [15:0] d, input logic e,
                      input logic o, input logic i, input logic c,
                      input logic [1:0] ex, input string tg);
    logic [7:0] sb;
    logic       any, ti;
    logic [1:0] ev;
    observe();
    adv_i = a; bus_data_i = d; st_even_i = e; st_odd_i = o; st_int_i = i;
    any = e | o;
    sb  = e ? mq[2][15:8] : mq[2][7:0];
    ti  = !mblk && (i || (mpend && any));
    ev  = ti ? 2'b01 : e ? 2'b10 : o ? 2'b11 : 2'b00;
    if (ti) begin mblk = 0; mpend = 0; end
    else begin
      if (i && mblk) mpend = 1;
      if (any) mblk = (sb == 8'h18);
    end
    mexec = mevt; mevt = ev; mmov = a ? 2'b10 : 2'b00;
    if (a) begin
      mq[2] = mq[1]; mq[1] = mq[0]; mq[0] = d;
      mv = {mv[1:0], 1'b1};
    end
    chk2 = chk1; exp2 = exp1; tag2 = tag1;
    chk1 = c; exp1 = ex; tag1 = tg;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; adv_i = 0; st_even_i = 0; st_odd_i = 0; st_int_i = 0;
    model_reset();
    phase_i = 1'b0; #1;
    chk("R1 move", {46'd0, qstat_o}, 48'd0);
    phase_i = 1'b1; #1;
    chk("R1 exec", {46'd0, qstat_o}, 48'd0);
    phase_i = 1'b0;
    chk("R1 stages", stage_o, 48'd0);
    chk("R1 valids", {45'd0, valid_o}, 48'd0);
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    // Fill queue with 0x1842 words
    for (int k = 0; k < 3; k++) step(1, 16'h1842, 0, 0, 0, 1, 2'b00, "R4 fill");
    step(0, 16'h0, 1, 0, 0, 1, 2'b10, "R6 even prebyte start");
    step(0, 16'h0, 0, 1, 1, 1, 2'b11, "R7 int blocked after prebyte");
    step(0, 16'h0, 0, 0, 0, 1, 2'b00, "R8 deferred without start");
    step(0, 16'h0, 1, 0, 0, 1, 2'b01, "R8 deferred int taken");
    step(0, 16'h0, 1, 0, 1, 1, 2'b01, "R9 int over start");
    step(0, 16'h0, 0, 1, 0, 1, 2'b11, "R6 odd start");
    step(0, 16'h0, 1, 1, 0, 1, 2'b10, "R6 even wins");
    for (int k = 0; k < 3; k++) step(1, 16'h4218, 0, 0, 0, 1, 2'b00, "R4 refill");
    step(0, 16'h0, 0, 1, 0, 1, 2'b11, "R6 odd prebyte start");
    step(0, 16'h0, 0, 0, 1, 1, 2'b00, "R7 blocked int alone");
    step(0, 16'h0, 1, 0, 0, 1, 2'b10, "R7 rest of instruction");
    step(0, 16'h0, 0, 1, 0, 1, 2'b01, "R8 pending int at next start");
    step(0, 16'h0, 0, 0, 0, 1, 2'b00, "R5 continue");
    step(0, 16'h0, 0, 0, 0, 1, 2'b00, "R3 hold");
    // Sweep all input combinations over several data patterns
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 16; c++) begin
        logic [15:0] d;
        d = (c % 3 == 0) ? 16'h18A5 : (c % 3 == 1) ? 16'h5A18 : 16'(c * 16'h1111 + r);
        step(c[0], d, c[1], c[2], c[3], 0, 2'b00, "");
      end
    end
    step(0, 16'h0, 0, 0, 0, 0, 2'b00, "");
    step(0, 16'h0, 0, 0, 0, 0, 2'b00, "");
    observe();
    // Reset after activity, with inputs active
    adv_i = 1; st_even_i = 1; st_int_i = 1; bus_data_i = 16'hFFFF;
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule